// File: doc/BRIEF.md
# Medium-Resolution Bitmap Scan Fetcher

This block sits between a 640x480 raster timing generator and a byte-wide screen memory that stores one bit per pixel. From the current column, line and active-video flag it forms the read address for the byte that holds the pixel. When that byte comes back, it picks the bit for the pixel. The picture is 320x240 and monochrome, so every stored pixel fills a 2x2 block of screen pixels.

The memory is not read as one linear framebuffer. The high address byte selects one of 120 rows of four screen lines each. Within a row, the even logical line occupies low offsets 0 to 39 and the odd logical line occupies offsets 128 to 167. Line bit 1 therefore lands in low-address bit 7. Inside a byte the least significant bit is the leftmost pixel. The memory answers a read one clock after the address, and the block applies a fixed two-clock latency from position inputs to the pixel output.

Top module: `mrf_scan_fetch`

## Requirements
- R1: While `rst_n` is low, and after its release until the first active cycle, `rd_addr_hi`, `rd_addr_lo` and `pix_out` are all 0.
- R2: One clock after a cycle with `vid_active` high, `rd_addr_hi` equals that cycle's `vpos` divided by 4 (integer), giving rows 0 to 119.
- R3: One clock after a cycle with `vid_active` high, `rd_addr_lo[7]` equals that cycle's `vpos[1]` and `rd_addr_lo[6]` is 0. Even logical lines therefore read offsets 0..39 and odd ones read 128..167.
- R4: One clock after a cycle with `vid_active` high, `rd_addr_lo[5:0]` equals that cycle's `hpos` divided by 16, which is in the range 0 to 39.
- R5: A cycle with `vid_active` low leaves both address bytes unchanged on the next clock, whatever `hpos` and `vpos` hold.
- R6: `rd_addr_hi` never exceeds 119, well below the memory ceiling of 140.
- R7: With the memory returning `rd_data` one clock after the address, `pix_out` two clocks after an active input cycle equals bit (`hpos`/2 mod 8) of the byte at the address formed from that cycle. Bit 0 is the leftmost pixel of the byte.
- R8: Screen columns 2k and 2k+1 show the same pixel, and screen lines 4r+2m and 4r+2m+1 read the same address.
- R9: `pix_out` is 0 two clocks after any cycle with `vid_active` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos | input | 10 | Current screen column from the timing generator |
| vpos | input | 10 | Current screen line from the timing generator |
| vid_active | input | 1 | High inside the 640x480 visible area |
| rd_data | input | 8 | Screen memory read data, one clock after the address |
| rd_addr_hi | output | 8 | Read address high byte (row) |
| rd_addr_lo | output | 8 | Read address low byte (line-half flag and byte column) |
| pix_out | output | 1 | Pixel value, two clocks after its position |

## Verification
The hardest behaviour to reach is the address holding steady while the inputs move through values that would be out of range. A real generator only shows those values in blanking, at columns 640 and up and lines past 479. To reach them, the stimulus compresses blanking into short runs that sweep those column and line values. It also inserts a brief drop of `vid_active` in the middle of a visible line. The selected lines include every residue of the line number modulo 4 at the top, middle and bottom of the frame, so both the even-offset and the 128-offset halves of each row are exercised at the first and last rows.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

    localparam int ADDR_BYTE_W = 8;

    typedef struct packed {
        logic [ADDR_BYTE_W-1:0] hi;
        logic [ADDR_BYTE_W-1:0] lo;
    } scr_addr_t;

endpackage

// File: rtl/mrf_addr_gen.sv
module mrf_addr_gen
    import mrf_pkg::*;
#(
    parameter int XW     = 10,
    parameter int YW     = 10,
    parameter int BYTE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] hpos,
    input  logic [YW-1:0] vpos,
    input  logic          vid_active,
    output scr_addr_t     addr_q
);

    localparam int SEL_W     = $clog2(BYTE_W);
    localparam int COL_SHIFT = SEL_W + 1;
    localparam int COL_W     = ADDR_BYTE_W - 2;
    localparam int ROW_SHIFT = 2;

    scr_addr_t addr_d;

    always_comb begin
        addr_d.hi = ADDR_BYTE_W'(vpos >> ROW_SHIFT);
        addr_d.lo = {vpos[1], 1'b0, COL_W'(hpos >> COL_SHIFT)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (vid_active) begin
            addr_q <= addr_d;
        end
    end

    // R5: blanking cycles leave the address untouched
    assert_hold_in_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_active |=> $stable(addr_q));

    // R2: row byte follows the line count divided by four
    assert_row_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vid_active |=> addr_q.hi == ADDR_BYTE_W'($past(vpos) >> ROW_SHIFT));

    // R3 / R8: odd screen lines share the line-half flag of the line before
    assert_half_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_active && vpos[0]) |=> addr_q.lo[7] == $past(vpos[1]));

endmodule

// File: rtl/mrf_pix_sel.sv
module mrf_pix_sel #(
    parameter int XW     = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XW-1:0]     hpos,
    input  logic              vid_active,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              pix_out
);

    localparam int SEL_W = $clog2(BYTE_W);

    logic [SEL_W-1:0] sel_s1, sel_s2;
    logic             act_s1, act_s2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_s1 <= '0;
            sel_s2 <= '0;
            act_s1 <= 1'b0;
            act_s2 <= 1'b0;
        end else begin
            sel_s1 <= hpos[SEL_W:1];
            act_s1 <= vid_active;
            sel_s2 <= sel_s1;
            act_s2 <= act_s1;
        end
    end

    always_comb begin
        pix_out = act_s2 & rd_data[sel_s2];
    end

endmodule

// File: rtl/mrf_scan_fetch.sv
module mrf_scan_fetch
    import mrf_pkg::*;
#(
    parameter int XW       = 10,
    parameter int YW       = 10,
    parameter int BYTE_W   = 8,
    parameter int ROW_LAST = 119
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XW-1:0]     hpos,
    input  logic [YW-1:0]     vpos,
    input  logic              vid_active,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [7:0]        rd_addr_hi,
    output logic [7:0]        rd_addr_lo,
    output logic              pix_out
);

    scr_addr_t addr_w;

    mrf_addr_gen #(.XW(XW), .YW(YW), .BYTE_W(BYTE_W)) addr_gen_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hpos       (hpos),
        .vpos       (vpos),
        .vid_active (vid_active),
        .addr_q     (addr_w)
    );

    mrf_pix_sel #(.XW(XW), .BYTE_W(BYTE_W)) pix_sel_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hpos       (hpos),
        .vid_active (vid_active),
        .rd_data    (rd_data),
        .pix_out    (pix_out)
    );

    assign rd_addr_hi = addr_w.hi;
    assign rd_addr_lo = addr_w.lo;

    // cycles since reset, saturating, so no property looks behind reset
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 3)  warm <= warm + 2'd1;
    end

    // R6: row byte never leaves the populated part of memory
    assert_row_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_hi <= 8'(ROW_LAST));

    // R3 / R4: bit 6 unused, byte column inside 0..39
    assert_col_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_addr_lo[6] && rd_addr_lo[5:0] < 6'd40);

    // R9: blank position gives a dark pixel two clocks later
    assert_dark_in_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2 && !$past(vid_active, 2)) |-> !pix_out);

    // R8: the odd column of a pair repeats the even one
    assert_col_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3 && $past(vid_active, 2) && $past(vid_active, 3) &&
         $past(hpos[0], 2) && $past(hpos, 2) == $past(hpos, 3) + 1'b1)
        |-> pix_out == $past(pix_out));

endmodule

// File: tb/mrf_scan_fetch_tb.sv
module mrf_scan_fetch_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] hpos = '0;
    logic [9:0] vpos = '0;
    logic       vid_active = 1'b0;
    logic [7:0] rd_data = '0;
    logic [7:0] rd_addr_hi, rd_addr_lo;
    logic       pix_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bit exp_pix_q[$];
    logic [7:0] m_hi = '0;
    logic [7:0] m_lo = '0;
    bit m_pushed_active = 0;

    always #10 clk = ~clk;

    mrf_scan_fetch dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hpos       (hpos),
        .vpos       (vpos),
        .vid_active (vid_active),
        .rd_data    (rd_data),
        .rd_addr_hi (rd_addr_hi),
        .rd_addr_lo (rd_addr_lo),
        .pix_out    (pix_out)
    );

    function automatic logic [7:0] pat(input logic [7:0] hi, input logic [7:0] lo);
        return 8'(hi * 8'd29) ^ 8'(lo * 8'd3) ^ 8'hA5;
    endfunction

    // memory model: one clock of read latency
    always @(posedge clk) rd_data <= pat(rd_addr_hi, rd_addr_lo);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d)", req, act, exp, hpos, vpos);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // one pixel clock: compare outputs, then drive the next position
    task automatic step(input int h, input int v, input bit a);
        logic [7:0] ehi, elo;
        @(negedge clk);
        if (m_pushed_active) begin
            check(rd_addr_hi == m_hi, "R2", rd_addr_hi, m_hi);
            check(rd_addr_lo[7:6] == m_lo[7:6], "R3", rd_addr_lo[7:6], m_lo[7:6]);
            check(rd_addr_lo[5:0] == m_lo[5:0], "R4", rd_addr_lo[5:0], m_lo[5:0]);
        end else begin
            check(rd_addr_hi == m_hi && rd_addr_lo == m_lo, "R5",
                  {rd_addr_hi, rd_addr_lo}, {m_hi, m_lo});
        end
        check(rd_addr_hi <= 8'd119, "R6", rd_addr_hi, 119);
        if (exp_pix_q.size() == 2) begin
            bit e = exp_pix_q.pop_front();
            check(pix_out == e, "R7/R8/R9", pix_out, e);
        end
        hpos = 10'(h);
        vpos = 10'(v);
        vid_active = a;
        ehi = 8'(v / 4);
        elo = {1'(v >> 1), 1'b0, 6'(h / 16)};
        if (a) begin
            exp_pix_q.push_back(pat(ehi, elo)[(h / 2) % 8]);
            m_hi = ehi;
            m_lo = elo;
        end else begin
            exp_pix_q.push_back(1'b0);
        end
        m_pushed_active = a;
    endtask

    task automatic line(input int v, input int gap);
        for (int h = 0; h < 640; h++) step(h, v, 1'b1);
        for (int g = 0; g < gap; g++) step(640 + g * 7, v, 1'b0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
                finish_run();
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(rd_addr_hi == 0 && rd_addr_lo == 0, "R1", {rd_addr_hi, rd_addr_lo}, 0);
        check(pix_out == 0, "R1", pix_out, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // blank cycles after reset with wild positions: still zero (R1, R5)
        for (int g = 0; g < 20; g++) step(700 + g, 500 + g, 1'b0);
        check(rd_addr_hi == 0 && rd_addr_lo == 0, "R1", {rd_addr_hi, rd_addr_lo}, 0);
        check(pix_out == 0, "R1", pix_out, 0);
        // top rows, all four line residues
        for (int v = 0; v < 8; v++) line(v, 16);
        // middle of frame
        for (int v = 236; v < 244; v++) line(v, 16);
        for (int v = 101; v < 103; v++) line(v, 16);
        // active drops briefly mid-line (R5, R9)
        for (int h = 0; h < 300; h++) step(h, 333, 1'b1);
        for (int h = 300; h < 304; h++) step(h, 333, 1'b0);
        for (int h = 304; h < 640; h++) step(h, 333, 1'b1);
        for (int g = 0; g < 16; g++) step(640 + g, 333, 1'b0);
        // bottom rows then vertical blanking with out-of-range lines
        for (int v = 472; v < 480; v++) line(v, 16);
        for (int v = 480; v < 525; v++)
            for (int g = 0; g < 12; g++) step(g * 66, v, 1'b0);
        // next frame starts again at row 0
        line(0, 16);
        line(2, 16);
        for (int g = 0; g < 4; g++) step(650, 2, 1'b0);
        finish_run();
    end

endmodule